// File: doc/BRIEF.md
# Serial Flash Page-Program Sequencer

This block takes a write request (a start address, a byte count and a stream of data bytes) and turns it into the command traffic that a serial flash engine needs in order to program that data. Flash program operations cannot cross a page boundary. The sequencer therefore divides the request into chunks that each stay within one 256-byte page.

Each chunk is wrapped in a fixed protocol. First the write-enable latch is set and read back until it shows as set. Then the chunk is programmed. Then the latch is cleared and read back until it shows as clear. The command port is command-level: it carries an opcode, an optional 3-byte address, a payload length and a read/write direction, with a valid/ready handshake. Payload bytes travel on a separate byte stream. Each command is closed by a response that carries an error flag and a status byte.

Bit-level shifting belongs to the engine behind the port. A host raises one request and waits for `done`.

Top module: `flpg_sequencer`

## Requirements
- R1: While and after reset, with no request applied, `busy`, `done`, `err`, `cmd_valid`, `tx_valid` and `in_ready` are all 0.
- R2: A request is issued as program chunks. Each chunk has length min(256 − (chunk address mod 256), bytes remaining). The next chunk address is the previous one plus its length, wrapping at 24 bits. So an unaligned start gives a short first chunk, then full 256-byte chunks, then any partial tail.
- R3: A request that fits within the remainder of its first page is issued as exactly one program command of the requested length.
- R4: A program command has opcode 0x02, `cmd_has_addr`=1, `cmd_read`=0, `cmd_addr` equal to the chunk start and `cmd_len` equal to the chunk length. Exactly `cmd_len` bytes pass in order from the input stream to the engine stream. The command fields stay steady while `cmd_valid` is high and `cmd_ready` is low.
- R5: Before each chunk the block sends opcode 0x06 (no address, length 0), then opcode 0x05 with `cmd_read`=1 and `cmd_len`=1. It repeats this pair until bit 1 of `rsp_status` reads 1.
- R6: After each chunk the block sends opcode 0x04, then the 0x05 status read. It repeats this pair until bit 1 of `rsp_status` reads 0. Only then does the next chunk begin.
- R7: Only the low 24 bits of `req_addr` are used; the upper bits have no effect on any command.
- R8: A response with `rsp_err`=1 on any command ends the request. No further command is issued, and `done` is raised with `err`=1.
- R9: A request with a byte count of 0 raises `done` in the cycle after acceptance and issues no command.
- R10: `busy` is high from the cycle after a request is accepted through the `done` cycle. A `req_valid` seen while `busy` is high is ignored.
- R11: `done` lasts one cycle, and `busy` is low in the following cycle. `err` is 0 at `done` for a request without error, and keeps its value until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_addr | input | IN_ADDR_W | Start address (low 24 bits used) |
| req_len | input | LEN_W | Byte count |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request ended on an engine error |
| in_valid | input | 1 | Source data byte valid |
| in_data | input | 8 | Source data byte |
| in_ready | output | 1 | Source byte taken |
| cmd_valid | output | 1 | Command offered to the engine |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_opcode | output | 8 | Command opcode |
| cmd_has_addr | output | 1 | Command carries a 3-byte address |
| cmd_addr | output | ADDR_W | Command address |
| cmd_len | output | CHUNK_W | Payload length in bytes |
| cmd_read | output | 1 | Payload is read from the flash |
| tx_valid | output | 1 | Program byte valid toward engine |
| tx_data | output | 8 | Program byte |
| tx_ready | input | 1 | Engine takes the program byte |
| rsp_valid | input | 1 | Command completion from engine |
| rsp_err | input | 1 | Command failed |
| rsp_status | input | 8 | Status byte from a status read |

## Verification
The hardest situations to reach from the ports are a write-enable latch that takes several attempts to change, and an engine failure in the middle of a multi-chunk request. Both would otherwise need a misbehaving flash. The bench engine model holds a latch state. It can be told to ignore a set number of enable and disable commands, which forces the sequencer's retry loops to run several times. It can also return an error on a chosen command index, such as the second program command, so the bench can check that the command and byte streams stop exactly there. Throughout, random back-pressure and gaps on both byte streams move the chunk boundaries relative to the stalls.

// File: rtl/flpg_pkg.sv
package flpg_pkg;
  localparam logic [7:0] OP_LATCH_SET = 8'h06;
  localparam logic [7:0] OP_LATCH_CLR = 8'h04;
  localparam logic [7:0] OP_STATUS    = 8'h05;
  localparam logic [7:0] OP_PROGRAM   = 8'h02;
  localparam int         LATCH_BIT    = 1;

  typedef enum logic [3:0] {
    S_IDLE,
    S_SET,
    S_SET_RSP,
    S_SET_POLL,
    S_SET_POLL_RSP,
    S_PROG,
    S_PROG_RSP,
    S_CLR,
    S_CLR_RSP,
    S_CLR_POLL,
    S_CLR_POLL_RSP,
    S_FINISH
  } seq_state_t;
endpackage

// File: rtl/flpg_chunker.sv
module flpg_chunker #(
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256,
  parameter int OFF_W      = $clog2(PAGE_BYTES),
  parameter int CHUNK_W    = OFF_W + 1
) (
  input  logic [OFF_W-1:0]   page_off,
  input  logic [LEN_W-1:0]   remaining,
  output logic [CHUNK_W-1:0] chunk_len
);
  logic [CHUNK_W-1:0] room;

  assign room      = CHUNK_W'(PAGE_BYTES) - {1'b0, page_off};
  assign chunk_len = (remaining < LEN_W'(room)) ? remaining[CHUNK_W-1:0] : room;

  // R2: a chunk is never empty and never runs past the page end
  always_comb begin
    if (remaining != '0) begin
      a_r2_chunk_fits: assert ((chunk_len != '0) &&
                               (({1'b0, page_off} + chunk_len) <= CHUNK_W'(PAGE_BYTES)));
    end
  end
endmodule

// File: rtl/flpg_stream_gate.sv
module flpg_stream_gate #(
  parameter int CHUNK_W = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               open,
  input  logic [CHUNK_W-1:0] limit,
  input  logic               in_valid,
  input  logic [7:0]         in_data,
  output logic               in_ready,
  output logic               tx_valid,
  output logic [7:0]         tx_data,
  input  logic               tx_ready
);
  logic [CHUNK_W-1:0] sent_q;
  logic               pass;

  assign pass     = open && (sent_q < limit);
  assign tx_valid = in_valid && pass;
  assign in_ready = tx_ready && pass;
  assign tx_data  = in_data;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sent_q <= '0;
    end else if (tx_valid && tx_ready) begin
      sent_q <= sent_q + 1'b1;
    end
  end

  // R4: never forwards more bytes than the chunk length
  a_r4_no_excess: assert property (@(posedge clk) disable iff (rst)
    sent_q <= limit);
endmodule

// File: rtl/flpg_ctrl.sv
module flpg_ctrl
  import flpg_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int IN_ADDR_W = 32,
  parameter int LEN_W     = 16,
  parameter int CHUNK_W   = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [IN_ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]     req_len,
  output logic                 busy,
  output logic                 done,
  output logic                 err,
  output logic                 cmd_valid,
  input  logic                 cmd_ready,
  output logic [7:0]           cmd_opcode,
  output logic                 cmd_has_addr,
  output logic [ADDR_W-1:0]    cmd_addr,
  output logic [CHUNK_W-1:0]   cmd_len,
  output logic                 cmd_read,
  input  logic                 rsp_valid,
  input  logic                 rsp_err,
  input  logic [7:0]           rsp_status,
  input  logic [CHUNK_W-1:0]   chunk_len,
  output logic [ADDR_W-1:0]    cur_addr,
  output logic [LEN_W-1:0]     remaining,
  output logic [CHUNK_W-1:0]   chunk_q,
  output logic                 prog_start,
  output logic                 prog_open
);
  seq_state_t state;
  logic       err_q;
  logic       rsp_wait;
  logic       latch_on;
  logic       unused_bits;

  assign unused_bits = ^{rsp_status, req_addr[IN_ADDR_W-1:ADDR_W]};
  assign latch_on    = rsp_status[LATCH_BIT];
  assign rsp_wait    = (state == S_SET_RSP) || (state == S_SET_POLL_RSP) ||
                       (state == S_PROG_RSP) || (state == S_CLR_RSP) ||
                       (state == S_CLR_POLL_RSP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cur_addr  <= '0;
      remaining <= '0;
      chunk_q   <= '0;
      err_q     <= 1'b0;
    end else if (rsp_wait && rsp_valid && rsp_err) begin
      err_q <= 1'b1;
      state <= S_FINISH;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          cur_addr  <= req_addr[ADDR_W-1:0];
          remaining <= req_len;
          err_q     <= 1'b0;
          state     <= (req_len == '0) ? S_FINISH : S_SET;
        end
        S_SET:          if (cmd_ready) state <= S_SET_RSP;
        S_SET_RSP:      if (rsp_valid) state <= S_SET_POLL;
        S_SET_POLL:     if (cmd_ready) state <= S_SET_POLL_RSP;
        S_SET_POLL_RSP: if (rsp_valid) state <= latch_on ? S_PROG : S_SET;
        S_PROG: if (cmd_ready) begin
          chunk_q <= chunk_len;
          state   <= S_PROG_RSP;
        end
        S_PROG_RSP: if (rsp_valid) begin
          cur_addr  <= cur_addr + ADDR_W'(chunk_q);
          remaining <= remaining - LEN_W'(chunk_q);
          state     <= S_CLR;
        end
        S_CLR:          if (cmd_ready) state <= S_CLR_RSP;
        S_CLR_RSP:      if (rsp_valid) state <= S_CLR_POLL;
        S_CLR_POLL:     if (cmd_ready) state <= S_CLR_POLL_RSP;
        S_CLR_POLL_RSP: if (rsp_valid) begin
          if (latch_on)              state <= S_CLR;
          else if (remaining == '0)  state <= S_FINISH;
          else                       state <= S_SET;
        end
        S_FINISH: state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_valid    = 1'b0;
    cmd_opcode   = 8'h00;
    cmd_has_addr = 1'b0;
    cmd_read     = 1'b0;
    cmd_len      = '0;
    case (state)
      S_SET: begin
        cmd_valid  = 1'b1;
        cmd_opcode = OP_LATCH_SET;
      end
      S_CLR: begin
        cmd_valid  = 1'b1;
        cmd_opcode = OP_LATCH_CLR;
      end
      S_SET_POLL, S_CLR_POLL: begin
        cmd_valid  = 1'b1;
        cmd_opcode = OP_STATUS;
        cmd_read   = 1'b1;
        cmd_len    = CHUNK_W'(1);
      end
      S_PROG: begin
        cmd_valid    = 1'b1;
        cmd_opcode   = OP_PROGRAM;
        cmd_has_addr = 1'b1;
        cmd_len      = chunk_len;
      end
      default: ;
    endcase
  end

  assign cmd_addr   = cur_addr;
  assign busy       = (state != S_IDLE);
  assign done       = (state == S_FINISH);
  assign err        = err_q;
  assign prog_start = (state == S_PROG) && cmd_ready;
  assign prog_open  = (state == S_PROG_RSP);

  // R4: an offered command does not change until it is taken
  a_r4_cmd_hold: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_opcode) &&
                                   $stable(cmd_addr) && $stable(cmd_len)));
  // R7: the first command address is the masked request address
  a_r7_addr_mask: assert property (@(posedge clk) disable iff (rst)
    ((state == S_IDLE) && req_valid && (req_len != '0)) |=>
      (cmd_addr == $past(req_addr[ADDR_W-1:0])));
  // R8: an engine error ends the request with the error flag
  a_r8_err_ends: assert property (@(posedge clk) disable iff (rst)
    (rsp_wait && rsp_valid && rsp_err) |=> (done && err && !cmd_valid));
  // R9: an empty request completes at once without commands
  a_r9_empty_done: assert property (@(posedge clk) disable iff (rst)
    ((state == S_IDLE) && req_valid && (req_len == '0)) |=> (done && !cmd_valid));
  // R10: busy cannot drop except through the completion cycle
  a_r10_busy_held: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);
  // R11: done lasts one cycle and busy falls after it
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));
endmodule

// File: rtl/flpg_sequencer.sv
module flpg_sequencer #(
  parameter int ADDR_W     = 24,
  parameter int IN_ADDR_W  = 32,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256,
  parameter int OFF_W      = $clog2(PAGE_BYTES),
  parameter int CHUNK_W    = OFF_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [IN_ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]     req_len,
  output logic                 busy,
  output logic                 done,
  output logic                 err,
  input  logic                 in_valid,
  input  logic [7:0]           in_data,
  output logic                 in_ready,
  output logic                 cmd_valid,
  input  logic                 cmd_ready,
  output logic [7:0]           cmd_opcode,
  output logic                 cmd_has_addr,
  output logic [ADDR_W-1:0]    cmd_addr,
  output logic [CHUNK_W-1:0]   cmd_len,
  output logic                 cmd_read,
  output logic                 tx_valid,
  output logic [7:0]           tx_data,
  input  logic                 tx_ready,
  input  logic                 rsp_valid,
  input  logic                 rsp_err,
  input  logic [7:0]           rsp_status
);
  logic [ADDR_W-1:0]  cur_addr;
  logic [LEN_W-1:0]   remaining;
  logic [CHUNK_W-1:0] chunk_len;
  logic [CHUNK_W-1:0] chunk_q;
  logic               prog_start;
  logic               prog_open;

  flpg_chunker #(
    .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W), .CHUNK_W(CHUNK_W)
  ) u_chunker (
    .page_off (cur_addr[OFF_W-1:0]),
    .remaining(remaining),
    .chunk_len(chunk_len)
  );

  flpg_ctrl #(
    .ADDR_W(ADDR_W), .IN_ADDR_W(IN_ADDR_W), .LEN_W(LEN_W), .CHUNK_W(CHUNK_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
    .busy(busy), .done(done), .err(err),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
    .cmd_has_addr(cmd_has_addr), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .cmd_read(cmd_read),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_status(rsp_status),
    .chunk_len(chunk_len), .cur_addr(cur_addr), .remaining(remaining),
    .chunk_q(chunk_q), .prog_start(prog_start), .prog_open(prog_open)
  );

  flpg_stream_gate #(
    .CHUNK_W(CHUNK_W)
  ) u_gate (
    .clk(clk), .rst(rst),
    .clear(prog_start), .open(prog_open), .limit(chunk_q),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
  );
endmodule

// File: tb/flpg_sequencer_bench.sv
module flpg_sequencer_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [31:0] req_addr  = '0;
  logic [15:0] req_len   = '0;
  logic        in_valid  = 1'b0;
  logic [7:0]  in_data   = '0;
  logic        cmd_ready = 1'b0;
  logic        tx_ready  = 1'b0;
  logic        rsp_valid = 1'b0;
  logic        rsp_err   = 1'b0;
  logic [7:0]  rsp_status = '0;
  logic        busy, done, err, in_ready, cmd_valid, cmd_has_addr, cmd_read, tx_valid;
  logic [7:0]  cmd_opcode, tx_data;
  logic [23:0] cmd_addr;
  logic [8:0]  cmd_len;

  flpg_sequencer u_flpg_sequencer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
    .busy(busy), .done(done), .err(err),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
    .cmd_has_addr(cmd_has_addr), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_read(cmd_read),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_status(rsp_status)
  );

  int checks = 0;
  int errors = 0;

  logic [7:0]  exp_op[$];
  logic [23:0] exp_addr[$];
  int          exp_len[$];
  logic [7:0]  exp_byte[$];
  logic [7:0]  src_q[$];

  int          e_phase = 0;
  int          e_left = 0;
  int          cmd_idx = 0;
  int          err_at = -1;
  int          set_skip = 0;
  int          clr_skip = 0;
  int          pp_count = 0;
  int          set_count = 0;
  int          clr_count = 0;
  int          cyc = 0;
  logic [7:0]  e_op = '0;
  logic        latch = 1'b0;
  logic        first_pp_seen = 1'b0;
  logic [23:0] first_pp_addr = '0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0]  pat = 8'h11;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // engine model and byte source, stepped on the falling edge
  always @(negedge clk) begin
    string tag;
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "R10", "watchdog expired", cyc, 0);
      summary();
      $finish;
    end
    lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    in_valid  = (src_q.size() > 0) && (lfsr[2] | lfsr[5]);
    in_data   = (src_q.size() > 0) ? src_q[0] : 8'h00;
    cmd_ready = 1'b0;
    rsp_valid = 1'b0;
    rsp_err   = 1'b0;
    tx_ready  = 1'b0;
    if (!rst) begin
      case (e_phase)
        0: if (cmd_valid) begin
          cmd_ready = 1'b1;
          e_op      = cmd_opcode;
          e_left    = int'(cmd_len);
          e_phase   = 1;
          tag = (cmd_opcode == 8'h06) ? "R5" : (cmd_opcode == 8'h04) ? "R6" :
                (cmd_opcode == 8'h02) ? "R4" : "R5";
          if (exp_op.size() == 0) begin
            chk(1'b0, "R8", "unexpected command opcode", cmd_opcode, 0);
          end else begin
            logic [7:0]  xo;
            logic [23:0] xa;
            int          xl;
            xo = exp_op.pop_front();
            xa = exp_addr.pop_front();
            xl = exp_len.pop_front();
            chk(cmd_opcode == xo, tag, "opcode", cmd_opcode, xo);
            chk(int'(cmd_len) == xl, tag, "payload length", cmd_len, xl);
            chk(cmd_read == (xo == 8'h05), tag, "read direction", cmd_read, xo == 8'h05);
            chk(cmd_has_addr == (xo == 8'h02), "R4", "address flag", cmd_has_addr, xo == 8'h02);
            if (xo == 8'h02) chk(cmd_addr == xa, "R2", "chunk address", cmd_addr, xa);
          end
          if (cmd_opcode == 8'h02) begin
            pp_count++;
            if (!first_pp_seen) begin
              first_pp_seen = 1'b1;
              first_pp_addr = cmd_addr;
            end
          end
          if (cmd_opcode == 8'h06) set_count++;
          if (cmd_opcode == 8'h04) clr_count++;
        end
        1: e_phase = (e_op == 8'h02) ? 2 : 3;
        2: if (e_left == 0) e_phase = 3;
           else tx_ready = lfsr[0] | lfsr[7];
        3: begin
          rsp_valid  = 1'b1;
          rsp_err    = (cmd_idx == err_at);
          rsp_status = {6'b0, latch, 1'b0};
          if (e_op == 8'h06) begin
            if (set_skip > 0) set_skip--; else latch = 1'b1;
          end
          if (e_op == 8'h04) begin
            if (clr_skip > 0) clr_skip--; else latch = 1'b0;
          end
          cmd_idx++;
          e_phase = 0;
        end
        default: e_phase = 0;
      endcase
    end
    #1;
    if (tx_valid && tx_ready) begin
      if (exp_byte.size() == 0) begin
        chk(1'b0, "R4", "unexpected program byte", tx_data, 0);
      end else begin
        logic [7:0] xb;
        xb = exp_byte.pop_front();
        chk(tx_data == xb, "R4", "program byte", tx_data, xb);
      end
      chk(in_ready == 1'b1, "R4", "source handshake", in_ready, 1);
      if (src_q.size() > 0) void'(src_q.pop_front());
      e_left--;
    end
  end

  task automatic push_cmd(input logic [7:0] op, input logic [23:0] a, input int n,
                          inout int idx, input int ea);
    if (ea < 0 || idx <= ea) begin
      exp_op.push_back(op);
      exp_addr.push_back(a);
      exp_len.push_back(n);
    end
    idx++;
  endtask

  task automatic run_req(input logic [31:0] a, input int n, input int ss, input int cs,
                         input int ea, input bit exp_err, input bit poke);
    logic [23:0] cur;
    int rem;
    int idx;
    bit first;
    int waited;
    cur = a[23:0];
    rem = n;
    idx = 0;
    first = 1'b1;
    exp_op.delete(); exp_addr.delete(); exp_len.delete();
    exp_byte.delete(); src_q.delete();
    set_skip = ss; clr_skip = cs; err_at = ea; cmd_idx = 0;
    pp_count = 0; set_count = 0; clr_count = 0; first_pp_seen = 1'b0;
    while (rem > 0) begin
      int ch;
      ch = 256 - int'(cur[7:0]);
      if (rem < ch) ch = rem;
      for (int k = 0; k <= (first ? ss : 0); k++) begin
        push_cmd(8'h06, 24'h0, 0, idx, ea);
        push_cmd(8'h05, 24'h0, 1, idx, ea);
      end
      if (ea < 0 || idx <= ea) begin
        for (int b = 0; b < ch; b++) begin
          pat = pat * 8'd5 + 8'd3;
          exp_byte.push_back(pat);
          src_q.push_back(pat);
        end
      end
      push_cmd(8'h02, cur, ch, idx, ea);
      for (int k = 0; k <= (first ? cs : 0); k++) begin
        push_cmd(8'h04, 24'h0, 0, idx, ea);
        push_cmd(8'h05, 24'h0, 1, idx, ea);
      end
      cur = cur + 24'(ch);
      rem = rem - ch;
      first = 1'b0;
    end
    @(negedge clk); #2;
    req_valid = 1'b1;
    req_addr  = a;
    req_len   = 16'(n);
    @(negedge clk); #2;
    req_valid = 1'b0;
    waited = 0;
    while (!done && waited < 20000) begin
      chk(busy, "R10", "busy while request runs", busy, 1);
      if (poke && waited == 5) begin
        req_valid = 1'b1;
        req_addr  = 32'h00FF_FF00;
        req_len   = 16'd5;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk); #2;
      waited++;
    end
    req_valid = 1'b0;
    if (n == 0) chk(done && waited == 0, "R9", "empty request completion delay", waited, 0);
    chk(done, "R11", "done reached", done, 1);
    chk(busy, "R10", "busy in done cycle", busy, 1);
    chk(err == exp_err, exp_err ? "R8" : "R11", "error flag at done", err, exp_err);
    chk(exp_op.size() == 0, "R2", "commands still expected", exp_op.size(), 0);
    chk(exp_byte.size() == 0, "R4", "bytes still expected", exp_byte.size(), 0);
    @(negedge clk); #2;
    chk(!done && !busy, "R11", "done single cycle then idle", {done, busy}, 0);
    chk(err == exp_err, "R11", "error flag held after done", err, exp_err);
    repeat (12) @(negedge clk);
    #2;
    chk(!busy, "R10", "ignored request left no activity", busy, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #2;
    chk(!busy && !done && !err, "R1", "status outputs in reset", {busy, done, err}, 0);
    chk(!cmd_valid, "R1", "command valid in reset", cmd_valid, 0);
    chk(!tx_valid && !in_ready, "R1", "stream handshakes in reset", {tx_valid, in_ready}, 0);
    rst = 1'b0;
    @(negedge clk); #2;
    chk(!busy && !cmd_valid && !in_ready, "R1", "idle after reset", {busy, cmd_valid, in_ready}, 0);

    // R9: empty request
    run_req(32'h0000_0123, 0, 0, 0, -1, 1'b0, 1'b0);
    chk(set_count == 0 && pp_count == 0, "R9", "commands for empty request", set_count + pp_count, 0);

    // R4: one aligned full page
    run_req(32'h0000_0100, 256, 0, 0, -1, 1'b0, 1'b0);
    chk(pp_count == 1, "R4", "program commands for aligned page", pp_count, 1);

    // R3: fits in first page remainder
    run_req(32'h0000_00F0, 8, 0, 0, -1, 1'b0, 1'b0);
    chk(pp_count == 1, "R3", "single chunk for short request", pp_count, 1);

    // R2 and R10: 16 + 256 + 256 + 72 with a request poked while busy
    run_req(32'h0000_12F0, 600, 0, 0, -1, 1'b0, 1'b1);
    chk(pp_count == 4, "R2", "chunk count for unaligned 600 bytes", pp_count, 4);

    // R7: upper address bits dropped
    run_req(32'hAB00_02FE, 4, 0, 0, -1, 1'b0, 1'b0);
    chk(first_pp_addr == 24'h0002FE, "R7", "masked start address", first_pp_addr, 24'h0002FE);
    chk(pp_count == 2, "R2", "split across page edge", pp_count, 2);

    // R2: wrap at the top of the 24-bit space
    run_req(32'h00FF_FFF0, 32, 0, 0, -1, 1'b0, 1'b0);
    chk(pp_count == 2, "R2", "split across address wrap", pp_count, 2);

    // R5 and R6: latch slow to change
    run_req(32'h0000_0040, 10, 2, 1, -1, 1'b0, 1'b0);
    chk(set_count == 3, "R5", "latch set attempts", set_count, 3);
    chk(clr_count == 2, "R6", "latch clear attempts", clr_count, 2);

    // R8: error on the second program command (command index 7)
    run_req(32'h0000_01F0, 300, 0, 0, 7, 1'b1, 1'b0);
    chk(pp_count == 2, "R8", "program commands before abandon", pp_count, 2);

    // R11: next clean request clears the error flag
    run_req(32'h0000_5000, 20, 0, 0, -1, 1'b0, 1'b0);

    summary();
    $finish;
  end
endmodule